// File: doc/BRIEF.md
# Three-wire serial EEPROM device controller

This block is the device-side logic of a small nonvolatile memory with a 1 Kbit register array that is reached over a three-wire serial bus. The bus has a select line, a serial clock, a data-in line and a data-out line. The master raises select and clocks in a frame on the data-in line. The frame holds a start bit, a two-bit opcode, an address and, for the store instructions, a data word. The block decodes the frame and runs one of seven instructions against its internal array: single read, single write, single erase, erase-all, write-all, unlock and lock. Stores stay locked from reset until the unlock instruction arrives. Each accepted store starts a program cycle whose length is set by a counter on the system clock. While that cycle runs, the block shows busy or ready on the data-out line.

A static strap input sets the word size. With the strap high, the array has 64 words of 16 bits and a frame carries a 6-bit address. With the strap low, it has 128 bytes and a frame carries a 7-bit address. The data-out line is modelled as a value plus an output enable, and the enable is low whenever the line would float. Select, serial clock, data-in and the strap are synchronised to the system clock, and the block reacts to the edges it detects on them.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low, stores are locked, and every array bit reads as 1.
- R2: Data-in is sampled on each serial clock rising edge. Zeros before the first 1 are ignored. That first 1 is the start bit, and it is followed by a 2-bit opcode and then the address, MSB first. The address is 6 bits with the strap high and 7 bits with the strap low.
- R3: On a read, the rising edge that takes the last address bit turns DO on and drives 0. Each following rising edge then presents the next word bit, MSB first, with 16 bits for a high strap and 8 bits for a low strap. The rising edge after the LSB turns DO off. Outside a read and a status display, the enable stays low.
- R4: The opcodes are read = 10, write = 01 and erase = 11. The opcode 00 uses the two top address bits: 11 unlocks, 00 locks, 10 erases all and 01 writes all. The rest of the address field is ignored.
- R5: From reset until an unlock, and again after a lock, the write, erase, erase-all and write-all instructions change nothing and start no program cycle.
- R6: A write stores the data bits that follow the address, MSB first. An erase sets the addressed location to all ones.
- R7: Erase-all sets every bit to 1. Write-all stores its data value in every location. With the strap low, that value fills both bytes of every 16-bit word.
- R8: With the strap low, byte address a lives in word a[6:1]. It is the upper half of that word when a[0] = 0 and the lower half when a[0] = 1.
- R9: An accepted store keeps the block busy for PROG_CYCLES system clocks. When select next rises, the enable goes high, and DO reads 0 while busy and 1 once ready.
- R10: While status is shown, a 1 clocked in on a rising edge keeps DO driven through that clock-high phase. DO is released at the next falling edge.
- R11: When select goes low, a partly shifted frame is dropped with no effect and the enable goes low.
- R12: A read or store whose frame ends while the program cycle runs is ignored: DO is not driven and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, times the program cycle and samples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Device select, active high |
| sk_i | input | 1 | Serial clock from the master |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Word-size strap: 1 = 16-bit words, 0 = 8-bit words |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Data out enable; low means the line floats |

## Verification
The hardest case to reach is an instruction whose frame finishes while a program cycle is still running. The bench stretches the program cycle to 600 system clocks. It starts a store without waiting, then reselects the device at once, so busy shows on DO. A start bit then releases that display, and a full read frame and a full erase frame follow inside the same cycle. A later read shows that neither frame had any effect. The bench also covers the release by a dummy 1 at the falling edge: it samples DO once in the clock-high phase after that 1 and once in the following low phase.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int WW    = 16;           // word width, wide organisation
  localparam int BW    = 8;            // byte width, narrow organisation
  localparam int AW16  = 6;            // address bits, wide
  localparam int AW8   = AW16 + 1;     // address bits, narrow
  localparam int WORDS = 1 << AW16;
  localparam int CW    = $clog2(WW + 1);
  localparam int IW    = $clog2(WW);

  typedef enum logic [2:0] {
    CMD_WRITE, CMD_ERASE, CMD_UNLOCK, CMD_LOCK, CMD_FILL1, CMD_FILLD
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } st_e;

  typedef enum logic [1:0] { K_READ, K_DATA, K_NOW } kind_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[gi] <= '0;
      else if (gi == 0) st_q[gi] <= d_i;
      else st_q[gi] <= st_q[(gi > 0) ? gi - 1 : 0];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int TW = $clog2(CYCLES + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= TW'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           org_i,
  input  logic           cmd_valid_i,
  input  cmd_e           cmd_i,
  input  logic [AW8-1:0] addr_i,
  input  logic [WW-1:0]  wdata_i,
  output logic [WW-1:0]  rd_data_o,
  output logic           prog_start_o
);
  logic [WW-1:0]   mem_q [WORDS];
  logic            wen_q;
  logic [AW16-1:0] wi;
  logic            hi;
  logic [WW-1:0]   fill;

  assign wi   = org_i ? addr_i[AW16-1:0] : addr_i[AW8-1:1];
  assign hi   = ~addr_i[0];
  assign fill = org_i ? wdata_i : {wdata_i[BW-1:0], wdata_i[BW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
      wen_q        <= 1'b0;
      prog_start_o <= 1'b0;
    end else begin
      prog_start_o <= 1'b0;
      if (cmd_valid_i) begin
        case (cmd_i)
          CMD_UNLOCK: wen_q <= 1'b1;
          CMD_LOCK:   wen_q <= 1'b0;
          default: if (wen_q) begin
            prog_start_o <= 1'b1;
            case (cmd_i)
              CMD_WRITE, CMD_ERASE: begin
                if (org_i) mem_q[wi] <= (cmd_i == CMD_ERASE) ? '1 : wdata_i;
                else if (hi) mem_q[wi][WW-1:BW] <= (cmd_i == CMD_ERASE) ? '1 : wdata_i[BW-1:0];
                else mem_q[wi][BW-1:0] <= (cmd_i == CMD_ERASE) ? '1 : wdata_i[BW-1:0];
              end
              CMD_FILL1: for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
              CMD_FILLD: for (int i = 0; i < WORDS; i++) mem_q[i] <= fill;
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_comb begin
    if (org_i) rd_data_o = mem_q[wi];
    else rd_data_o = {{(WW-BW){1'b0}}, hi ? mem_q[wi][WW-1:BW] : mem_q[wi][BW-1:0]};
  end
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_i,
  input  logic           cs_rise_i,
  input  logic           sk_rise_i,
  input  logic           sk_fall_i,
  input  logic           di_i,
  input  logic           org_i,
  input  logic           busy_i,
  input  logic           prog_start_i,
  input  logic [WW-1:0]  rd_data_i,
  output logic           cmd_valid_o,
  output cmd_e           cmd_o,
  output logic [AW8-1:0] addr_o,
  output logic [WW-1:0]  wdata_o,
  output logic           do_o,
  output logic           do_oe_o
);
  st_e            st_q;
  logic [CW-1:0]  cnt_q;
  logic [1:0]     op_q;
  logic           rd_on_q, rd_bit_q;
  logic           stat_pend_q, stat_show_q, rel_q;
  logic [AW8-1:0] addr_nx;
  logic [1:0]     top2;
  logic [CW-1:0]  aw_m1, dw_m1, dw_c;
  logic [IW-1:0]  rd_idx;
  kind_e          kind;
  cmd_e           dec_cmd;

  always_comb begin
    addr_nx = {addr_o[AW8-2:0], di_i};
    top2    = org_i ? addr_nx[AW16-1:AW16-2] : addr_nx[AW8-1:AW8-2];
    aw_m1   = org_i ? CW'(AW16 - 1) : CW'(AW8 - 1);
    dw_c    = org_i ? CW'(WW) : CW'(BW);
    dw_m1   = dw_c - 1'b1;
    rd_idx  = IW'(dw_m1 - cnt_q);
    kind    = K_NOW;
    dec_cmd = CMD_ERASE;
    case (op_q)
      2'b10: kind = K_READ;
      2'b01: begin kind = K_DATA; dec_cmd = CMD_WRITE; end
      2'b11: dec_cmd = CMD_ERASE;
      default: case (top2)
        2'b11:   dec_cmd = CMD_UNLOCK;
        2'b00:   dec_cmd = CMD_LOCK;
        2'b10:   dec_cmd = CMD_FILL1;
        default: begin kind = K_DATA; dec_cmd = CMD_FILLD; end
      endcase
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; op_q <= '0; addr_o <= '0; wdata_o <= '0;
      cmd_o <= CMD_LOCK; cmd_valid_o <= 1'b0; rd_on_q <= 1'b0; rd_bit_q <= 1'b0;
      stat_pend_q <= 1'b0; stat_show_q <= 1'b0; rel_q <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (!cs_i) begin
        st_q <= ST_IDLE; rd_on_q <= 1'b0; stat_show_q <= 1'b0; rel_q <= 1'b0;
      end else begin
        if (cs_rise_i && stat_pend_q) stat_show_q <= 1'b1;
        if (stat_show_q && sk_rise_i && di_i) rel_q <= 1'b1;
        if (rel_q && sk_fall_i) begin
          stat_show_q <= 1'b0; rel_q <= 1'b0; stat_pend_q <= 1'b0;
        end
        if (sk_rise_i) begin
          case (st_q)
            ST_IDLE: if (di_i) begin
              st_q <= ST_OP; cnt_q <= '0; addr_o <= '0; wdata_o <= '0;
            end
            ST_OP: begin
              op_q  <= {op_q[0], di_i};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CW'(1)) begin st_q <= ST_ADDR; cnt_q <= '0; end
            end
            ST_ADDR: begin
              addr_o <= addr_nx;
              cnt_q  <= cnt_q + 1'b1;
              if (cnt_q == aw_m1) begin
                cnt_q <= '0;
                cmd_o <= dec_cmd;
                case (kind)
                  K_READ: if (!busy_i) begin
                    st_q <= ST_READ; rd_on_q <= 1'b1; rd_bit_q <= 1'b0;
                  end else st_q <= ST_DONE;
                  K_DATA: st_q <= ST_DATA;
                  default: begin st_q <= ST_DONE; cmd_valid_o <= !busy_i; end
                endcase
              end
            end
            ST_DATA: begin
              wdata_o <= {wdata_o[WW-2:0], di_i};
              cnt_q   <= cnt_q + 1'b1;
              if (cnt_q == dw_m1) begin st_q <= ST_DONE; cmd_valid_o <= !busy_i; end
            end
            ST_READ: begin
              if (cnt_q == dw_c) begin rd_on_q <= 1'b0; st_q <= ST_DONE; end
              else begin rd_bit_q <= rd_data_i[rd_idx]; cnt_q <= cnt_q + 1'b1; end
            end
            default: ;
          endcase
        end
      end
      if (prog_start_i) stat_pend_q <= 1'b1;
    end
  end

  assign do_oe_o = rd_on_q | stat_show_q;
  assign do_o    = stat_show_q ? ~busy_i : rd_bit_q;
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  logic cs_s, sk_s, di_s, org_s, sk_d, cs_d;
  logic cmd_valid, prog_start, busy;
  cmd_e cmd;
  logic [AW8-1:0] addr;
  logic [WW-1:0]  wdata, rd_data;

  mw_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i({cs_i, sk_i, di_i, org_i}), .q_o({cs_s, sk_s, di_s, org_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin sk_d <= 1'b0; cs_d <= 1'b0; end
    else begin sk_d <= sk_s; cs_d <= cs_s; end
  end

  mw_frame i_frame (
    .clk_i, .rst_ni, .cs_i(cs_s), .cs_rise_i(cs_s & ~cs_d),
    .sk_rise_i(sk_s & ~sk_d), .sk_fall_i(~sk_s & sk_d), .di_i(di_s), .org_i(org_s),
    .busy_i(busy), .prog_start_i(prog_start), .rd_data_i(rd_data),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .addr_o(addr), .wdata_o(wdata),
    .do_o, .do_oe_o
  );

  mw_array i_array (
    .clk_i, .rst_ni, .org_i(org_s), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .addr_i(addr), .wdata_i(wdata), .rd_data_o(rd_data), .prog_start_o(prog_start)
  );

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
    .clk_i, .rst_ni, .start_i(prog_start), .busy_o(busy)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic cmd_valid,
  input logic prog_start,
  input logic busy,
  input logic do_oe_o
);
  // R11
  cs_low_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !do_oe_o);
  // R9
  busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |=> busy);
  // R5
  start_needs_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |-> $past(cmd_valid));
  // R12
  no_cmd_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid |-> !$past(busy));
  // R3
  drive_only_selected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(do_oe_o) |-> cs_s);
endmodule

bind mw_eeprom mw_eeprom_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .cmd_valid(cmd_valid),
  .prog_start(prog_start), .busy(busy), .do_oe_o(do_oe_o)
);

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
  localparam int PROG   = 600;
  localparam int SETTLE = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_v, do_oe;
  int   n_chk = 0, n_fail = 0;
  logic [15:0] mem_m [64];
  bit   we_m = 0;

  always #2 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG)) i_mw_eeprom (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
    .do_o(do_v), .do_oe_o(do_oe)
  );

  function automatic logic [15:0] m_read(input int a);
    if (org) return mem_m[a & 63];
    if ((a & 1) == 0) return {8'h00, mem_m[(a >> 1) & 63][15:8]};
    return {8'h00, mem_m[(a >> 1) & 63][7:0]};
  endfunction

  task automatic m_wr(input int a, input logic [15:0] v);
    if (org) mem_m[a & 63] = v;
    else if ((a & 1) == 0) mem_m[(a >> 1) & 63][15:8] = v[7:0];
    else mem_m[(a >> 1) & 63][7:0] = v[7:0];
  endtask

  task automatic sample(input logic eoe, input logic edo, input string tag);
    n_chk++;
    if (do_oe !== eoe || (eoe && do_v !== edo)) begin
      n_fail++;
      $display("FAIL %s: oe/do actual %b/%b expected %b/%b at %0t", tag, do_oe, do_v, eoe, edo, $time);
    end
  endtask

  task automatic tick(input logic d, input logic hoe, input logic hdo,
                      input logic loe, input logic ldo, input string tag);
    di = d; repeat (2) @(negedge clk);
    sk = 1'b1; repeat (SETTLE) @(negedge clk); sample(hoe, hdo, tag); repeat (2) @(negedge clk);
    sk = 1'b0; repeat (SETTLE) @(negedge clk); sample(loe, ldo, tag); repeat (2) @(negedge clk);
  endtask

  task automatic cs_up();
    cs = 1'b1; repeat (SETTLE) @(negedge clk);
  endtask

  task automatic cs_down();
    cs = 1'b0; di = 1'b0; repeat (SETTLE) @(negedge clk);
    sample(1'b0, 1'b0, "R11");
  endtask

  task automatic raw_frame(input logic [31:0] v, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) tick(v[i], 0, 0, 0, 0, tag);
  endtask

  task automatic status_poll();
    cs_up();
    sample(1'b1, 1'b0, "R9");
    repeat (PROG + 20) @(negedge clk);
    sample(1'b1, 1'b1, "R9");
    tick(1'b1, 1, 1, 0, 0, "R10");
    cs_down();
  endtask

  task automatic do_read(input int a, input int lead, input string tag);
    int aw = org ? 6 : 7;
    int dw = org ? 16 : 8;
    logic [6:0]  av = 7'(a);
    logic [15:0] e = m_read(a);
    cs_up();
    for (int i = 0; i < lead; i++) tick(0, 0, 0, 0, 0, "R2");
    raw_frame(32'b110, 3, "R2");
    for (int i = aw - 1; i >= 1; i--) tick(av[i], 0, 0, 0, 0, "R2");
    tick(av[0], 1, 0, 1, 0, "R3");
    for (int k = dw - 1; k >= 0; k--) tick(0, 1, e[k], 1, e[k], tag);
    tick(0, 0, 0, 0, 0, "R3");
    cs_down();
  endtask

  task automatic send_cmd(input logic [1:0] op, input int a, input logic [15:0] d, input bit poll);
    int aw = org ? 6 : 7;
    int dw = org ? 16 : 8;
    int top2 = (a >> (aw - 2)) & 3;
    bit has_d = (op == 2'b01) || (op == 2'b00 && top2 == 1);
    bit acc = 0;
    logic [31:0] v = 32'd1;
    int n = 3 + aw;
    v = (v << 2) | 32'(op);
    v = (v << aw) | 32'(a & ((1 << aw) - 1));
    if (has_d) begin v = (v << dw) | 32'(d & ((1 << dw) - 1)); n += dw; end
    cs_up(); raw_frame(v, n, "R4"); cs_down();
    case (op)
      2'b01: if (we_m) begin m_wr(a, d); acc = 1; end
      2'b11: if (we_m) begin m_wr(a, 16'hFFFF); acc = 1; end
      default: case (top2)
        3: we_m = 1;
        0: we_m = 0;
        2: if (we_m) begin for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF; acc = 1; end
        default: if (we_m) begin
          for (int i = 0; i < 64; i++) mem_m[i] = org ? d : {d[7:0], d[7:0]};
          acc = 1;
        end
      endcase
    endcase
    if (acc && poll) status_poll();
  endtask

  task automatic set_org(input logic o);
    org = o; repeat (SETTLE) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sample(1'b0, 1'b0, "R1");
    do_read(5, 0, "R1");
    // R5: locked after reset
    send_cmd(2'b01, 5, 16'h1234, 1);
    do_read(5, 0, "R5");
    // R4 unlock, R6 write
    send_cmd(2'b00, 48, 16'h0, 1);
    send_cmd(2'b01, 5, 16'hA5C3, 1);
    do_read(5, 2, "R6");
    send_cmd(2'b01, 63, 16'h8001, 1);
    do_read(63, 0, "R2");
    send_cmd(2'b11, 5, 16'h0, 1);
    do_read(5, 0, "R6");
    // R8 narrow organisation
    set_org(1'b0);
    send_cmd(2'b01, 127, 16'h005A, 1);
    do_read(127, 0, "R8");
    do_read(126, 1, "R8");
    set_org(1'b1);
    do_read(63, 0, "R8");
    // R7 erase-all, write-all
    send_cmd(2'b00, 32, 16'h0, 1);
    do_read(63, 0, "R7");
    send_cmd(2'b00, 16, 16'h3C3C, 1);
    do_read(17, 0, "R7");
    set_org(1'b0);
    send_cmd(2'b00, 64, 16'h0077, 1);
    do_read(0, 0, "R7");
    set_org(1'b1);
    do_read(40, 0, "R8");
    // R5 relock
    send_cmd(2'b00, 0, 16'h0, 1);
    send_cmd(2'b01, 1, 16'h0000, 1);
    do_read(1, 0, "R5");
    // R11 abort of a partial frame
    send_cmd(2'b00, 48, 16'h0, 1);
    cs_up(); raw_frame({19'b0, 1'b1, 2'b01, 6'd2, 4'b0000}, 13, "R11"); cs_down();
    do_read(2, 0, "R11");
    // R12 frames that end during the program cycle
    send_cmd(2'b01, 10, 16'h1111, 0);
    cs_up();
    sample(1'b1, 1'b0, "R12");
    tick(1'b1, 1, 0, 0, 0, "R12");
    raw_frame({22'b0, 2'b10, 6'd10, 2'b00}, 10, "R12");
    cs_down();
    cs_up(); raw_frame({23'b0, 1'b1, 2'b11, 6'd10}, 9, "R12"); cs_down();
    repeat (PROG + 50) @(negedge clk);
    do_read(10, 0, "R12");
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule